// File: doc/BRIEF.md
# Grouped Random Bit-Flip Mask Generator

This block produces a flip mask that a neighbouring datapath can XOR into a hash word to model random bit errors. The hash word is divided into equal 64-bit groups. Each group draws 14 bits from a 128-bit pseudo-random state. Six of those bits pick one bit position inside the group. The other eight are a probability sample. The picked bit is set in the mask only when the sample falls below a threshold derived from a rational rate `RATE_NUM / RATE_DEN`. As a result, each group flips at most one bit per mask.

The random state is a 128-bit xorshift generator. An active-low asynchronous reset loads it with the 64-bit seed repeated twice. It moves forward by exactly one step on each rising clock edge where `step_en` is high. The mask is a purely combinational function of the current state, so a new mask is available on the cycle after each step. The block has no states beyond the generator register itself. Its two implicit modes are "hold" (`step_en` low) and "advance" (`step_en` high), and reset overrides both.

Elaboration stops with a fatal error if any of these conditions is broken:
- the hash width is not 64 times the group count;
- the group count times 14 exceeds 128;
- `RATE_DEN` is not positive;
- `RATE_NUM` lies outside 0..`RATE_DEN`;
- the seed is zero.

Top module: `grp_flip_mask_gen`

## Requirements
- R1: While `rst_n` is low, the random state equals `{SEED, SEED}` (SEED in bits 127:64 and again in 63:0). The state is loaded asynchronously and is never advanced during reset, and `mask_o` reflects that state at once.
- R2: One step treats the state as four 32-bit words: a = bits 127:96, b = 95:64, c = 63:32, d = 31:0. With t = a ^ (a << 11), the next state is {b, c, d, d ^ (d >> 19) ^ t ^ (t >> 8)}. A nonzero state never becomes zero or repeats itself in one step.
- R3: On a rising edge with `step_en` low, the state is unchanged, and so is `mask_o`.
- R4: Group g (g = 0 .. GROUPS-1) covers mask bits g*64 .. g*64+63. It uses state bits g*14 .. g*14+13. Of those, bits 5:0 give the bit index within the group and bits 13:6 give the 8-bit sample.
- R5: The threshold is RATE_NUM*256/RATE_DEN, using integer division. A group's indexed bit is 1 exactly when its sample is strictly below the threshold. All other bits of the group are 0, so each group has at most one set bit.
- R6: With RATE_NUM = 0, `mask_o` is all zeros on every cycle.
- R7: With RATE_NUM = RATE_DEN, every group of `mask_o` has exactly one set bit on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; reloads the seed |
| step_en | input | 1 | Advance the random state by one step at this edge |
| mask_o | output | HASH_W | Flip mask, one candidate bit per 64-bit group |

## Verification
Some properties are checked by the bound assertions on every clocked cycle:
- the state stays nonzero and changes on every enabled step;
- the state stays frozen on every idle edge;
- no group ever carries more than one set bit;
- for the boundary rates, the mask is all zero (rate 0) or has exactly one bit per group (full rate).

Other properties are shown only by the bench's scenarios, which compare the full mask on every cycle against an arithmetic reference:
- the exact xorshift sequence;
- the slice positions of index and sample;
- the strict less-than threshold comparison;
- the seed reload during a reset asserted in the middle of the run.

// File: rtl/grp_flip_pkg.sv
`timescale 1ns / 1ps
package grp_flip_pkg;
    localparam int GRP_W   = 64;
    localparam int IDX_W   = 6;
    localparam int SMP_W   = 8;
    localparam int SLICE_W = IDX_W + SMP_W;
    localparam int RND_W   = 128;
    localparam int SMP_SPAN = 1 << SMP_W;

    localparam int SH_A = 11;
    localparam int SH_B = 8;
    localparam int SH_C = 19;

    // One xorshift128 step on four 32-bit words, a in the top word
    function automatic logic [RND_W-1:0] xs_advance(input logic [RND_W-1:0] cur);
        logic [31:0] wa, wb, wc, wd, tmp, nw;
        wa  = cur[127:96];
        wb  = cur[95:64];
        wc  = cur[63:32];
        wd  = cur[31:0];
        tmp = wa ^ (wa << SH_A);
        nw  = wd ^ (wd >> SH_C) ^ tmp ^ (tmp >> SH_B);
        return {wb, wc, wd, nw};
    endfunction
endpackage

// File: rtl/xs128_state.sv
`timescale 1ns / 1ps
module xs128_state
    import grp_flip_pkg::*;
#(
    parameter logic [63:0] SEED = 64'h243F_6A88_85A3_08D3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [RND_W-1:0] state_o
);
    localparam logic [RND_W-1:0] INIT = {SEED, SEED};

    logic [RND_W-1:0] state_q;
    logic [RND_W-1:0] state_d;

    always_comb begin
        state_d = state_q;
        if (adv) begin
            state_d = xs_advance(state_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/flip_lane.sv
`timescale 1ns / 1ps
module flip_lane
    import grp_flip_pkg::*;
#(
    parameter logic [SMP_W:0] THR = '0
) (
    input  logic [SLICE_W-1:0] slice_i,
    output logic [GRP_W-1:0]   lane_o
);
    logic [IDX_W-1:0] pos;
    logic [SMP_W-1:0] smp;

    assign pos = slice_i[IDX_W-1:0];
    assign smp = slice_i[SLICE_W-1:IDX_W];

    always_comb begin
        lane_o = '0;
        if ({1'b0, smp} < THR) begin
            lane_o[pos] = 1'b1;
        end
    end
endmodule

// File: rtl/grp_flip_mask_gen.sv
`timescale 1ns / 1ps
module grp_flip_mask_gen
    import grp_flip_pkg::*;
#(
    parameter int          HASH_W   = 512,
    parameter int          GROUPS   = 8,
    parameter int          RATE_NUM = 1,
    parameter int          RATE_DEN = 100,
    parameter logic [63:0] SEED     = 64'h243F_6A88_85A3_08D3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    output logic [HASH_W-1:0] mask_o
);
    localparam int USED_W  = GROUPS * SLICE_W;
    localparam int THR_INT = (RATE_DEN > 0) ? (RATE_NUM * SMP_SPAN) / RATE_DEN : 0;
    localparam logic [SMP_W:0] THR = THR_INT[SMP_W:0];

    initial begin
        if (GROUPS <= 0)
            $fatal(1, "group count must be positive");
        if (HASH_W != GROUPS * GRP_W)
            $fatal(1, "hash width %0d is not %0d groups of 64", HASH_W, GROUPS);
        if (USED_W > RND_W)
            $fatal(1, "groups need %0d random bits, only 128 exist", USED_W);
        if (RATE_DEN <= 0)
            $fatal(1, "rate denominator must be positive");
        if (RATE_NUM < 0 || RATE_NUM > RATE_DEN)
            $fatal(1, "rate numerator %0d outside 0..%0d", RATE_NUM, RATE_DEN);
        if (SEED == 64'd0)
            $fatal(1, "seed must be nonzero");
    end

    logic [RND_W-1:0] rnd_state;

    xs128_state #(
        .SEED (SEED)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (step_en),
        .state_o (rnd_state)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
        flip_lane #(
            .THR (THR)
        ) u_lane (
            .slice_i (rnd_state[g*SLICE_W +: SLICE_W]),
            .lane_o  (mask_o[g*GRP_W +: GRP_W])
        );
    end

    logic unused_rnd_hi;
    assign unused_rnd_hi = ^rnd_state[RND_W-1:USED_W];
endmodule

// File: rtl/grp_flip_mask_chk.sv
`timescale 1ns / 1ps
module grp_flip_mask_chk #(
    parameter int HASH_W   = 512,
    parameter int GROUPS   = 8,
    parameter int RATE_NUM = 1,
    parameter int RATE_DEN = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic [127:0]      state,
    input logic [HASH_W-1:0] mask
);
    assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    assert_step_changes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> state != $past(state));

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(state) && $stable(mask));

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assert_single_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(mask[g*64 +: 64]) <= 1);

        if (RATE_NUM == RATE_DEN) begin : g_full
            assert_full_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(mask[g*64 +: 64]) == 1);
        end
    end

    if (RATE_NUM == 0) begin : g_zero
        assert_zero_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
            mask == '0);
    end
endmodule

bind grp_flip_mask_gen grp_flip_mask_chk #(
    .HASH_W   (HASH_W),
    .GROUPS   (GROUPS),
    .RATE_NUM (RATE_NUM),
    .RATE_DEN (RATE_DEN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .state   (rnd_state),
    .mask    (mask_o)
);

// File: tb/tb_grp_flip_mask_gen.sv
`timescale 1ns / 1ps
module tb_grp_flip_mask_gen;
    localparam logic [63:0] SEED = 64'h9E37_79B9_7F4A_7C15;
    localparam int N_CYC = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_en = 1'b0;
    logic [255:0] mask_main;
    logic [127:0] mask_zero;
    logic [191:0] mask_full;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [127:0] model;

    always #4 clk = ~clk;

    // rate 3/8 -> threshold 96
    grp_flip_mask_gen #(.HASH_W(256), .GROUPS(4), .RATE_NUM(3), .RATE_DEN(8), .SEED(SEED))
        dut (.clk(clk), .rst_n(rst_n), .step_en(step_en), .mask_o(mask_main));
    grp_flip_mask_gen #(.HASH_W(128), .GROUPS(2), .RATE_NUM(0), .RATE_DEN(5), .SEED(SEED))
        dut_zero (.clk(clk), .rst_n(rst_n), .step_en(step_en), .mask_o(mask_zero));
    grp_flip_mask_gen #(.HASH_W(192), .GROUPS(3), .RATE_NUM(7), .RATE_DEN(7), .SEED(SEED))
        dut_full (.clk(clk), .rst_n(rst_n), .step_en(step_en), .mask_o(mask_full));

    function automatic logic [127:0] ref_step(input logic [127:0] s);
        logic [31:0] a, b, c, d, t;
        a = s[127:96]; b = s[95:64]; c = s[63:32]; d = s[31:0];
        t = a ^ (a << 11);
        t = t ^ (t >> 8);
        return {b, c, d, (d ^ (d >> 19)) ^ t};
    endfunction

    function automatic logic [511:0] ref_mask(input logic [127:0] s, input int ng, input int thr);
        logic [511:0] m;
        m = '0;
        for (int g = 0; g < ng; g++) begin
            int sl;
            sl = int'((s >> (g * 14)) & 128'h3FFF);
            if ((sl / 64) < thr) m[g * 64 + (sl % 64)] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [511:0] em, ez, ef;
        em = ref_mask(model, 4, 96);
        ez = '0;
        ef = ref_mask(model, 3, 256);
        check(mask_main == em[255:0], {req, " R4 R5 main"}, {256'd0, mask_main}, em);
        check(mask_zero == ez[127:0], "R6 zero-rate", {384'd0, mask_zero}, ez);
        check(mask_full == ef[191:0], {req, " R7 full-rate"}, {320'd0, mask_full}, ef);
        for (int g = 0; g < 3; g++) begin
            check($countones(mask_full[g*64 +: 64]) == 1, "R7 one bit per group",
                  512'($countones(mask_full[g*64 +: 64])), 512'd1);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model = {SEED, SEED};
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        for (int i = 0; i < N_CYC; i++) begin
            bit en;
            @(negedge clk);
            if (i == 1700) begin
                // R1: asynchronous reload mid-run, enable high must not advance
                rst_n = 1'b0;
                step_en = 1'b1;
                model = {SEED, SEED};
                #1;
                check_all("R1 async reload");
                @(negedge clk);
                check_all("R1 held in reset");
                rst_n = 1'b1;
            end
            check_all("R2 R3 sweep");
            if (i >= 400 && i < 460) en = 1'b0;
            else en = ((i % 11) < 7) || (i % 13 == 0);
            step_en = en;
            if (en) model = ref_step(model);
        end
        @(negedge clk);
        check_all("R2 R3 final");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule